// File: doc/BRIEF.md
# Time-Scheduled Square-Wave Pin Generator

This block drives one output pin as a square wave locked to a free-running time value. The time value counts 8 ns ticks. Software loads a 64-bit first-edge time and a 32-bit half-period, also in ticks. It then writes a command word with its strobe. When the start command is accepted, the first edge is scheduled. The pin inverts on the first cycle whose time value is at or beyond that edge time. From then on it inverts once per half-period, which gives a 50 % duty cycle at a frequency of 1e9 / (2 x 8 x half-period) Hz. The pin never returns to a rest level between edges.

The start command is accepted only when the requested first edge lies strictly in the future and the half-period is nonzero. A rejected start changes nothing. A stop command freezes the pin wherever it is and disarms the schedule. A later start arms it again from freshly supplied values. Only one output channel is provided.

Top module: `pdo_periodic_out`

## Requirements
- R1: After reset the pin is low and disarmed. While disarmed the pin never changes.
- R2: A start is the command word with bit 28 set, written with the strobe high. It is accepted only when the first-edge time is strictly greater than the current time value. An equal or earlier first-edge time leaves the pin and the schedule unchanged.
- R3: A start with a half-period of zero is ignored, and the pin does not change.
- R4: Once a start is accepted, the pin inverts after the first clock edge at which the sampled time value is greater than or equal to the first-edge time.
- R5: After each edge the next edge time is advanced by the half-period. The number of pin inversions over a window therefore equals the number of scheduled edge times that the time value has reached.
- R6: A stop is bit 27 of the command word, written with the strobe high. It freezes the pin at its current level and disarms the schedule. A later accepted start resumes toggling from the newly supplied first-edge time.
- R7: When bits 27 and 28 are both set in one write, the stop wins and nothing is armed.
- R8: A stop sampled in the same cycle as a due edge suppresses that edge, so the pin keeps its level.
- R9: If the time value jumps past the scheduled edge without ever equalling it, the edge is still produced once.
- R10: Command bits other than 27 and 28 have no effect. Command words presented without the strobe have no effect.
- R11: An accepted start while already running replaces the schedule with the new first-edge time and half-period. The pin keeps its current level.
- R12: Every nonzero 32-bit half-period is accepted, up to and including the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptp_time_i | input | 64 | Current time value in 8 ns ticks |
| start_time_i | input | 64 | Requested first-edge time in ticks |
| half_period_i | input | 32 | Ticks between consecutive pin edges |
| cmd_we_i | input | 1 | Strobe qualifying the command word |
| cmd_word_i | input | 32 | Command word: bit 28 start, bit 27 stop |
| pin_o | output | 1 | Square-wave output pin |

## Verification
Two things can land in one clock cycle: a command arriving over the strobe, and an edge whose scheduled time the counter has just reached. The bench provokes this collision on purpose. It arms an edge, waits until the time value presented to the block equals that edge time, and issues a stop in exactly that cycle. The run passes only if the pin then holds its earlier level for the rest of the window. The bench also re-arms a running schedule with a new start and checks that the inversions that follow match the new schedule alone, not the old one.

// File: rtl/pdo_pkg.sv
`timescale 1ns/1ps
package pdo_pkg;

    // Decoded command for one cycle; stop outranks start.
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_START = 2'd1,
        CMD_STOP  = 2'd2
    } pdo_cmd_e;

endpackage

// File: rtl/pdo_cmd_decode.sv
`timescale 1ns/1ps
module pdo_cmd_decode
    import pdo_pkg::*;
#(
    parameter int unsigned CMD_W     = 32,
    parameter int unsigned START_BIT = 28,
    parameter int unsigned STOP_BIT  = 27
) (
    input  logic             we_i,
    input  logic [CMD_W-1:0] word_i,
    output pdo_cmd_e         cmd_o
);

    // Bits outside the two command flags are deliberately not decoded.
    logic unused_word;
    assign unused_word = ^word_i;

    always_comb begin
        cmd_o = CMD_NONE;
        if (we_i) begin
            if (word_i[STOP_BIT]) begin
                cmd_o = CMD_STOP;
            end else if (word_i[START_BIT]) begin
                cmd_o = CMD_START;
            end
        end
    end

endmodule

// File: rtl/pdo_time_cmp.sv
`timescale 1ns/1ps
module pdo_time_cmp #(
    parameter int unsigned W      = 64,
    parameter bit          STRICT = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o
);

    generate
        if (STRICT) begin : g_gt
            assign hit_o = (a_i > b_i);
        end else begin : g_ge
            assign hit_o = (a_i >= b_i);
        end
    endgenerate

endmodule

// File: rtl/pdo_edge_sched.sv
`timescale 1ns/1ps
module pdo_edge_sched
    import pdo_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  pdo_cmd_e          cmd_i,
    input  logic              start_ok_i,
    input  logic [TIME_W-1:0] start_time_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              edge_due_i,
    output logic [TIME_W-1:0] next_edge_o,
    output logic              pin_o
);

    typedef struct packed {
        logic              armed;
        logic              pin;
        logic [TIME_W-1:0] next_edge;
        logic [HALF_W-1:0] half;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i == CMD_STOP) begin
            st_d.armed = 1'b0;
        end else if (cmd_i == CMD_START && start_ok_i) begin
            st_d.armed     = 1'b1;
            st_d.next_edge = start_time_i;
            st_d.half      = half_i;
        end else if (st_q.armed && edge_due_i) begin
            st_d.pin       = ~st_q.pin;
            st_d.next_edge = st_q.next_edge + TIME_W'(st_q.half);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_edge_o = st_q.next_edge;
    assign pin_o       = st_q.pin;

    // R1: a disarmed schedule never moves the pin
    p_idle_pin_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.armed |=> $stable(st_q.pin));

    // R6, R8: stop disarms and freezes the pin even if an edge was due
    p_stop_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_STOP) |=> (!st_q.armed && $stable(st_q.pin)));

    // R2, R11: accepted start loads the first-edge time without moving the pin
    p_accept_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_START && start_ok_i)
        |=> (st_q.armed && st_q.next_edge == $past(start_time_i) && $stable(st_q.pin)));

    // R3: a rejected start leaves a disarmed schedule disarmed
    p_reject_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_START && !start_ok_i && !st_q.armed)
        |=> (!st_q.armed && $stable(st_q.pin)));

    // R3: an armed schedule never holds a zero half-period
    p_half_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.armed |-> (st_q.half != '0));

    // R5: a due edge inverts the pin and advances by one half-period
    p_edge_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_NONE && st_q.armed && edge_due_i)
        |=> (st_q.pin != $past(st_q.pin)
             && st_q.next_edge == $past(st_q.next_edge) + TIME_W'($past(st_q.half))));

endmodule

// File: rtl/pdo_periodic_out.sv
`timescale 1ns/1ps
module pdo_periodic_out
    import pdo_pkg::*;
#(
    parameter int unsigned TIME_W    = 64,
    parameter int unsigned HALF_W    = 32,
    parameter int unsigned CMD_W     = 32,
    parameter int unsigned START_BIT = 28,
    parameter int unsigned STOP_BIT  = 27
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] ptp_time_i,
    input  logic [TIME_W-1:0] start_time_i,
    input  logic [HALF_W-1:0] half_period_i,
    input  logic              cmd_we_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    output logic              pin_o
);

    pdo_cmd_e          cmd;
    logic              start_future;
    logic              start_ok;
    logic              edge_due;
    logic [TIME_W-1:0] next_edge;

    pdo_cmd_decode #(
        .CMD_W     (CMD_W),
        .START_BIT (START_BIT),
        .STOP_BIT  (STOP_BIT)
    ) u_dec (
        .we_i   (cmd_we_i),
        .word_i (cmd_word_i),
        .cmd_o  (cmd)
    );

    // First edge must lie strictly after the current time.
    pdo_time_cmp #(.W(TIME_W), .STRICT(1'b1)) u_future (
        .a_i   (start_time_i),
        .b_i   (ptp_time_i),
        .hit_o (start_future)
    );

    // An edge is due once time has reached or passed it.
    pdo_time_cmp #(.W(TIME_W), .STRICT(1'b0)) u_due (
        .a_i   (ptp_time_i),
        .b_i   (next_edge),
        .hit_o (edge_due)
    );

    assign start_ok = start_future && (half_period_i != '0);

    pdo_edge_sched #(
        .TIME_W (TIME_W),
        .HALF_W (HALF_W)
    ) u_sched (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmd_i        (cmd),
        .start_ok_i   (start_ok),
        .start_time_i (start_time_i),
        .half_i       (half_period_i),
        .edge_due_i   (edge_due),
        .next_edge_o  (next_edge),
        .pin_o        (pin_o)
    );

endmodule

// File: tb/sim_pdo_periodic_out.sv
`timescale 1ns/1ps
module sim_pdo_periodic_out;

    localparam logic [31:0] W_START = 32'h1000_0000;
    localparam logic [31:0] W_STOP  = 32'h0800_0000;

    typedef struct packed {
        logic [31:0] hp;
        int          d;
        int          w;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{32'd4,          10, 40},
        '{32'd1,           2, 20},
        '{32'd3,           0, 30},
        '{32'd3,          -5, 30},
        '{32'd0,           5, 30},
        '{32'd7,          50, 40},
        '{32'hFFFF_FFFF,   2, 30},
        '{32'd5,           1, 26}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now = 64'd1000;
    logic [63:0] skip = 64'd0;
    logic [63:0] start_time = '0;
    logic [31:0] half = '0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        pin;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) now <= now + 64'd1 + skip;

    pdo_periodic_out u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ptp_time_i    (now),
        .start_time_i  (start_time),
        .half_period_i (half),
        .cmd_we_i      (cmd_we),
        .cmd_word_i    (cmd_word),
        .pin_o         (pin)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Called at a negedge; returns at the negedge after the command edge.
    task automatic send(input longint d, input logic [31:0] hp,
                        input logic [31:0] word, output longint n0);
        n0         = longint'(now);
        start_time = 64'(n0 + d);
        half       = hp;
        cmd_word   = word;
        cmd_we     = 1'b1;
        @(negedge clk);
        cmd_we   = 1'b0;
        cmd_word = '0;
    endtask

    task automatic count_toggles(input int w, output int cnt);
        logic prev;
        prev = pin;
        cnt  = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (pin != prev) cnt++;
            prev = pin;
        end
    endtask

    function automatic int exp_edges(longint n0, longint d, logic [31:0] hp, int w);
        longint s, l;
        if (d <= 0 || hp == 0) return 0;
        s = n0 + d;
        l = n0 + w;
        if (s > l) return 0;
        return int'((l - s) / longint'({32'd0, hp}) + 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        longint n0;
        int     cnt;
        int     e;
        logic   p0;
        string  tag;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset level", pin, 0);
        count_toggles(10, cnt);
        check("R1 idle toggles", cnt, 0);

        // R10: start bit without strobe, and strobe with unrelated bits
        start_time = now + 64'd3;
        half       = 32'd2;
        cmd_word   = W_START;
        count_toggles(20, cnt);
        check("R10 no strobe", cnt, 0);
        cmd_word = '0;
        send(3, 32'd2, 32'h2000_0001, n0);
        count_toggles(20, cnt);
        check("R10 other bits", cnt, 0);

        // Vector table: stop, start, count inversions, check final level
        for (int v = 0; v < NV; v++) begin
            send(0, 32'd1, W_STOP, n0);
            p0 = pin;
            send(VEC[v].d, VEC[v].hp, W_START, n0);
            count_toggles(VEC[v].w, cnt);
            e = exp_edges(n0, VEC[v].d, VEC[v].hp, VEC[v].w);
            if (VEC[v].d <= 0)              tag = "R2";
            else if (VEC[v].hp == 0)        tag = "R3";
            else if (VEC[v].hp > 32'd100000) tag = "R12";
            else                            tag = "R4 R5";
            check({tag, " inversions"}, cnt, e);
            check({tag, " final level"}, pin, p0 ^ e[0]);
        end

        // R6: stop freezes, later start resumes
        send(0, 32'd1, W_STOP, n0);
        send(3, 32'd2, W_START, n0);
        count_toggles(10, cnt);
        check("R6 running before stop", cnt, exp_edges(n0, 3, 32'd2, 10));
        send(0, 32'd1, W_STOP, n0);
        p0 = pin;
        count_toggles(20, cnt);
        check("R6 frozen toggles", cnt, 0);
        check("R6 frozen level", pin, p0);
        send(4, 32'd3, W_START, n0);
        count_toggles(20, cnt);
        check("R6 resume", cnt, exp_edges(n0, 4, 32'd3, 20));

        // R7: both bits in one write
        send(0, 32'd1, W_STOP, n0);
        send(3, 32'd2, W_START | W_STOP, n0);
        count_toggles(20, cnt);
        check("R7 stop wins", cnt, 0);

        // R8: stop sampled exactly when the first edge is due
        send(6, 32'd4, W_START, n0);
        repeat (5) @(negedge clk);
        check("R8 time at edge", longint'(now), n0 + 6);
        p0 = pin;
        send(0, 32'd1, W_STOP, n0);
        count_toggles(20, cnt);
        check("R8 edge suppressed", cnt, 0);
        check("R8 level kept", pin, p0);

        // R11: re-arm while running
        send(2, 32'd3, W_START, n0);
        repeat (8) @(negedge clk);
        p0 = pin;
        send(5, 32'd6, W_START, n0);
        check("R11 level kept", pin, p0);
        count_toggles(30, cnt);
        check("R11 new schedule", cnt, exp_edges(n0, 5, 32'd6, 30));

        // R9: time jumps past the first edge
        send(0, 32'd1, W_STOP, n0);
        send(5, 32'd1000, W_START, n0);
        skip = 64'd49;
        @(negedge clk);
        skip = 64'd0;
        count_toggles(20, cnt);
        check("R9 passed edge", cnt, 1);

        finish_run();
    end

endmodule